// File: doc/BRIEF.md
# Timer Capture/Compare Channel with Protected Event Flag

One channel of a general-purpose timer. It sits beside a free-running counter, whose value and overflow pulse arrive as ports, and beside a CPU register bus, which reaches it through read and write strobes. The channel works in one of two modes.

In capture mode, a chosen edge on the input pin copies the counter value into the channel value register. In compare mode, a match between the counter and the channel value register drives the output pin. That output can be set, cleared or toggled on a match, toggled on each counter overflow, or held high for full duty. Either kind of event raises an event flag. The flag asks for an interrupt when the enable bit is set.

Software clears the flag in two steps. It first reads the status/control register while the flag is set, then writes 0 to the flag bit. A small state machine tracks this handshake with two states:

- **CLR_IDLE**: no clear is authorised. The transition *arm* goes to CLR_ARMED on a read that sees the flag set, when no event arrives in that cycle.
- **CLR_ARMED**: a clear is authorised. The transition *cancel* returns to CLR_IDLE on any new event. The transition *consume* returns to CLR_IDLE on any register write.

A second two-state machine holds the compare output level, with states **LVL_LOW** and **LVL_HIGH**. Its transitions are *set*, *clear* and *toggle*. A parameter builds a variant in which the upper mode bit reads 0 and ignores writes.

Top module: `tmr_chan`

## Requirements
- R1: While reset is asserted, the status/control readback, the channel value readback, pin_out and irq are all 0.
- R2: Status/control bit positions are: 7 flag, 6 interrupt enable, 5 upper mode bit, 4 lower mode bit, 3:2 edge/action select, 1 toggle-on-overflow, 0 full-duty. A write loads bits 6:0 and they read back unchanged. Writing 1 to bit 7 never sets or clears the flag.
- R3: In capture mode (mode bits 00), the edge select picks the event. 01 selects rising edges, 10 selects falling edges, 11 selects both, and 00 ignores the pin. The flag is set at the clock edge that first samples the new pin level.
- R4: On a capture event, the counter value is copied into the channel value register in the same cycle.
- R5: In compare mode (either mode bit 1), the flag is set at the clock edge where the counter equals the channel value register.
- R6: A read that sees the flag set, followed by a write with bit 7 = 0, clears the flag.
- R7: A write of 0 to bit 7 does not clear the flag without a prior read that saw it set. Any write consumes that authorisation, even a write with bit 7 = 1.
- R8: An event between the arming read and the clearing write leaves the flag set after the write.
- R9: irq is 1 exactly when the flag and the interrupt enable bit are both 1.
- R10: On a compare match, the select field sets the output level. 01 toggles it, 10 drives it low, and 11 drives it high.
- R11: With toggle-on-overflow set in compare mode, each overflow pulse toggles the output level. When a match with select 01, 10 or 11 falls in the same cycle as an overflow, the match action wins, so a compare value of 0 gives 0% duty.
- R12: In compare mode with a non-zero select, the full-duty bit forces pin_out to 1.
- R13: With HAS_MSB = 0, bit 5 reads 0 and writes to it are ignored.
- R14: pin_out is 0 in capture mode, and in compare mode with select 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Free-running counter value |
| cnt_ovf | input | 1 | Counter overflow pulse |
| pin_in | input | 1 | Channel input pin |
| sc_rd | input | 1 | Status/control read strobe |
| sc_wr | input | 1 | Status/control write strobe |
| sc_wdata | input | 8 | Status/control write data |
| sc_rdata | output | 8 | Status/control readback |
| val_wr | input | 1 | Channel value write strobe |
| val_wdata | input | CNT_W | Channel value write data |
| val_rdata | output | CNT_W | Channel value readback |
| pin_out | output | 1 | Channel output pin |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check four things on every cycle:
- the flag rises only after an event;
- it falls only after an armed write of 0;
- an event always leaves it set;
- irq tracks flag and enable, and pin_out respects the full-duty and disconnected settings.

Only the bench scenarios can show the rest. These are:
- which edge each select code picks, and the counter value latched on it;
- the timing of the read/write clearing handshake, including a stale read and an intervening event;
- the output level after set, clear and toggle actions;
- the priority of a match over an overflow that gives 0% duty.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    typedef enum logic {
        CLR_IDLE,
        CLR_ARMED
    } clr_state_e;

    typedef enum logic {
        LVL_LOW,
        LVL_HIGH
    } out_lvl_e;

    typedef enum logic [1:0] {
        ELS_OFF = 2'b00,
        ELS_A   = 2'b01,
        ELS_B   = 2'b10,
        ELS_AB  = 2'b11
    } els_e;

    typedef struct packed {
        logic ie;
        logic msb;
        logic msa;
        els_e els;
        logic tov;
        logic maxd;
    } ctrl_t;

    localparam int unsigned SC_W     = 8;
    localparam int unsigned FLAG_BIT = SC_W - 1;

endpackage

// File: rtl/tmr_chan_edge.sv
module tmr_chan_edge
    import tmr_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic en,
    input  els_e els,
    output logic hit
);

    logic pin_d;
    logic rise;
    logic fall;
    logic sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_d <= 1'b0;
        else        pin_d <= pin_in;
    end

    assign rise = pin_in & ~pin_d;
    assign fall = ~pin_in & pin_d;

    always_comb begin
        unique case (els)
            ELS_OFF: sel = 1'b0;
            ELS_A:   sel = rise;
            ELS_B:   sel = fall;
            ELS_AB:  sel = rise | fall;
        endcase
    end

    assign hit = en & sel;

endmodule

// File: rtl/tmr_chan_flag.sv
module tmr_chan_flag
    import tmr_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic rd,
    input  logic wr,
    input  logic wbit,
    output logic flag,
    output logic armed
);

    clr_state_e state_q;
    clr_state_e state_d;
    logic       flag_q;
    logic       do_clear;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CLR_IDLE;
        else        state_q <= state_d;
    end

    // next state: arm / cancel / consume
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CLR_IDLE: begin
                if (rd && flag_q && !evt) state_d = CLR_ARMED;
            end
            CLR_ARMED: begin
                if (evt || wr) state_d = CLR_IDLE;
            end
        endcase
    end

    assign do_clear = (state_q == CLR_ARMED) && wr && !wbit && !evt;

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (evt)      flag_q <= 1'b1;
        else if (do_clear) flag_q <= 1'b0;
    end

    assign flag  = flag_q;
    assign armed = (state_q == CLR_ARMED);

endmodule

// File: rtl/tmr_chan_out.sv
module tmr_chan_out
    import tmr_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  els_e els,
    input  logic tov,
    input  logic maxd,
    input  logic cmp_hit,
    input  logic ovf,
    output logic pin_out
);

    out_lvl_e lvl_q;
    out_lvl_e lvl_d;

    function automatic out_lvl_e flip(input out_lvl_e l);
        return (l == LVL_HIGH) ? LVL_LOW : LVL_HIGH;
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= LVL_LOW;
        else        lvl_d_apply: lvl_q <= lvl_d;
    end

    // next state: a match action has priority over an overflow toggle
    always_comb begin
        lvl_d = lvl_q;
        if (active && cmp_hit && (els != ELS_OFF)) begin
            unique case (els)
                ELS_A:   lvl_d = flip(lvl_q);
                ELS_B:   lvl_d = LVL_LOW;
                ELS_AB:  lvl_d = LVL_HIGH;
                default: lvl_d = lvl_q;
            endcase
        end else if (active && ovf && tov) begin
            lvl_d = flip(lvl_q);
        end
    end

    // outputs
    always_comb begin
        pin_out = active && (els != ELS_OFF) && (maxd || (lvl_q == LVL_HIGH));
    end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_chan_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter bit          HAS_MSB = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_ovf,
    input  logic             pin_in,
    input  logic             sc_rd,
    input  logic             sc_wr,
    input  logic [7:0]       sc_wdata,
    output logic [7:0]       sc_rdata,
    input  logic             val_wr,
    input  logic [CNT_W-1:0] val_wdata,
    output logic [CNT_W-1:0] val_rdata,
    output logic             pin_out,
    output logic             irq
);

    ctrl_t            ctrl_q;
    ctrl_t            ctrl_wr;
    logic [CNT_W-1:0] val_q;
    logic             is_cmp;
    logic             cap_hit;
    logic             cmp_hit;
    logic             evt;
    logic             flag;
    logic             armed;

    always_comb begin
        ctrl_wr = ctrl_t'(sc_wdata[FLAG_BIT-1:0]);
        if (!HAS_MSB) ctrl_wr.msb = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ctrl_q <= '0;
        else if (sc_wr) ctrl_q <= ctrl_wr;
    end

    assign is_cmp = ctrl_q.msb | ctrl_q.msa;

    tmr_chan_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .en     (!is_cmp),
        .els    (ctrl_q.els),
        .hit    (cap_hit)
    );

    // a capture has priority over a bus write of the value register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       val_q <= '0;
        else if (cap_hit) val_q <= cnt_val;
        else if (val_wr)  val_q <= val_wdata;
    end

    assign cmp_hit = is_cmp && (cnt_val == val_q);
    assign evt     = cap_hit | cmp_hit;

    tmr_chan_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .rd    (sc_rd),
        .wr    (sc_wr),
        .wbit  (sc_wdata[FLAG_BIT]),
        .flag  (flag),
        .armed (armed)
    );

    tmr_chan_out u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (is_cmp),
        .els     (ctrl_q.els),
        .tov     (ctrl_q.tov),
        .maxd    (ctrl_q.maxd),
        .cmp_hit (cmp_hit),
        .ovf     (cnt_ovf),
        .pin_out (pin_out)
    );

    assign sc_rdata  = {flag, ctrl_q};
    assign val_rdata = val_q;
    assign irq       = flag & ctrl_q.ie;

endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
    parameter bit HAS_MSB = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sc_wr,
    input logic [7:0] sc_wdata,
    input logic [7:0] sc_rdata,
    input logic       pin_out,
    input logic       irq,
    input logic       evt,
    input logic       armed
);

    assert_irq_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (sc_rdata[7] && sc_rdata[6]));

    assert_flag_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sc_rdata[7]) |-> $past(evt));

    assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sc_rdata[7]) |-> $past(armed && sc_wr && !sc_wdata[7]));

    assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> sc_rdata[7]);

    assert_full_duty_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((|sc_rdata[5:4]) && (|sc_rdata[3:2]) && sc_rdata[0]) |-> pin_out);

    assert_pin_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
        ((sc_rdata[3:2] == 2'b00) || (sc_rdata[5:4] == 2'b00)) |-> !pin_out);

    generate
        if (!HAS_MSB) begin : g_no_msb
            assert_msb_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
                !sc_rdata[5]);
        end
    endgenerate

endmodule

bind tmr_chan tmr_chan_chk #(.HAS_MSB(HAS_MSB)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sc_wr    (sc_wr),
    .sc_wdata (sc_wdata),
    .sc_rdata (sc_rdata),
    .pin_out  (pin_out),
    .irq      (irq),
    .evt      (evt),
    .armed    (armed)
);

// File: tb/tmr_chan_tb_top.sv
module tmr_chan_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_val = 16'h1234;
    logic        cnt_ovf = 1'b0;
    logic        pin_in = 1'b0;
    logic        sc_rd = 1'b0;
    logic        sc_wr = 1'b0;
    logic [7:0]  sc_wdata = 8'h00;
    logic        val_wr = 1'b0;
    logic [15:0] val_wdata = 16'h0000;
    logic [7:0]  sc_rdata, sc_rdata_b;
    logic [15:0] val_rdata, val_rdata_b;
    logic        pin_out, pin_out_b, irq, irq_b;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    tmr_chan dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_ovf(cnt_ovf),
        .pin_in(pin_in), .sc_rd(sc_rd), .sc_wr(sc_wr), .sc_wdata(sc_wdata),
        .sc_rdata(sc_rdata), .val_wr(val_wr), .val_wdata(val_wdata),
        .val_rdata(val_rdata), .pin_out(pin_out), .irq(irq)
    );

    tmr_chan #(.HAS_MSB(1'b0)) dut_b (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_ovf(cnt_ovf),
        .pin_in(pin_in), .sc_rd(sc_rd), .sc_wr(sc_wr), .sc_wdata(sc_wdata),
        .sc_rdata(sc_rdata_b), .val_wr(val_wr), .val_wdata(val_wdata),
        .val_rdata(val_rdata_b), .pin_out(pin_out_b), .irq(irq_b)
    );

    // {write data, expected readback (default), expected readback (no upper mode bit)}
    localparam logic [23:0] VEC_TAB [0:4] = '{
        24'hFF_7F_5F,
        24'h80_00_00,
        24'h2A_2A_0A,
        24'h55_55_55,
        24'h00_00_00
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sc_write(input logic [7:0] d);
        sc_wr = 1'b1;
        sc_wdata = d;
        tick();
        sc_wr = 1'b0;
    endtask

    task automatic sc_read();
        sc_rd = 1'b1;
        tick();
        sc_rd = 1'b0;
    endtask

    task automatic val_write(input logic [15:0] d);
        val_wr = 1'b1;
        val_wdata = d;
        tick();
        val_wr = 1'b0;
    endtask

    // put the counter on the match value for one edge, then move it off
    task automatic hit_match();
        cnt_val = 16'h0010;
        tick();
        cnt_val = 16'h0011;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick();
        tick();
        chk("R1 sc_rdata", {24'h0, sc_rdata}, 32'h0);
        chk("R1 val_rdata", {16'h0, val_rdata}, 32'h0);
        chk("R1 pin_out", {31'h0, pin_out}, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        rst_n = 1'b1;
        tick();

        for (int i = 0; i < 5; i++) begin
            sc_write(VEC_TAB[i][23:16]);
            chk("R2 readback", {24'h0, sc_rdata}, {24'h0, VEC_TAB[i][15:8]});
            chk("R13 readback", {24'h0, sc_rdata_b}, {24'h0, VEC_TAB[i][7:0]});
        end

        // capture, rising edges
        sc_write(8'h04);
        cnt_val = 16'h1111; pin_in = 1'b1; tick();
        chk("R3 rise flag", {31'h0, sc_rdata[7]}, 32'h1);
        chk("R4 capture value", {16'h0, val_rdata}, 32'h1111);
        sc_read(); sc_write(8'h04);
        chk("R6 clear", {24'h0, sc_rdata}, 32'h04);
        cnt_val = 16'h2222; pin_in = 1'b0; tick();
        chk("R3 fall ignored in rise mode", {31'h0, sc_rdata[7]}, 32'h0);
        chk("R4 value kept", {16'h0, val_rdata}, 32'h1111);

        // falling edges
        sc_write(8'h08);
        pin_in = 1'b1; tick();
        chk("R3 rise ignored in fall mode", {31'h0, sc_rdata[7]}, 32'h0);
        pin_in = 1'b0; tick();
        chk("R3 fall flag", {31'h0, sc_rdata[7]}, 32'h1);
        chk("R4 fall capture", {16'h0, val_rdata}, 32'h2222);
        sc_read(); sc_write(8'h08);

        // both edges
        sc_write(8'h0C);
        cnt_val = 16'h3333; pin_in = 1'b1; tick();
        chk("R3 both rise", {16'h0, val_rdata}, 32'h3333);
        sc_read(); sc_write(8'h0C);
        cnt_val = 16'h4444; pin_in = 1'b0; tick();
        chk("R3 both fall", {31'h0, sc_rdata[7]}, 32'h1);
        chk("R4 both fall value", {16'h0, val_rdata}, 32'h4444);

        // clear without authorisation
        sc_write(8'h0C);
        chk("R7 write without read", {31'h0, sc_rdata[7]}, 32'h1);
        sc_read(); sc_write(8'h8C);
        chk("R2 write one to flag", {31'h0, sc_rdata[7]}, 32'h1);
        sc_write(8'h0C);
        chk("R7 consumed by earlier write", {31'h0, sc_rdata[7]}, 32'h1);
        sc_read(); sc_write(8'h0C);
        chk("R6 armed clear", {31'h0, sc_rdata[7]}, 32'h0);

        // event between read and write
        cnt_val = 16'h5555; pin_in = 1'b1; tick();
        sc_read();
        pin_in = 1'b0; tick();
        sc_write(8'h0C);
        chk("R8 event cancels clear", {31'h0, sc_rdata[7]}, 32'h1);
        sc_read(); sc_write(8'h0C);

        // pin disconnected
        sc_write(8'h00);
        cnt_val = 16'h6666; pin_in = 1'b1; tick();
        pin_in = 1'b0; tick();
        chk("R3 select off flag", {31'h0, sc_rdata[7]}, 32'h0);
        chk("R3 select off value", {16'h0, val_rdata}, 32'h5555);

        // interrupt request
        sc_write(8'h4C);
        pin_in = 1'b1; tick();
        chk("R9 irq raised", {31'h0, irq}, 32'h1);
        sc_read(); sc_write(8'h4C);
        chk("R9 irq dropped", {31'h0, irq}, 32'h0);
        pin_in = 1'b0; tick();
        sc_write(8'h0C);
        chk("R9 irq masked", {31'h0, irq}, 32'h0);
        sc_read(); sc_write(8'h0C);

        // output compare, toggle
        cnt_val = 16'h0005;
        val_write(16'h0010);
        sc_write(8'h14);
        chk("R10 idle low", {31'h0, pin_out}, 32'h0);
        hit_match();
        chk("R5 compare flag", {31'h0, sc_rdata[7]}, 32'h1);
        chk("R10 toggle high", {31'h0, pin_out}, 32'h1);
        hit_match();
        chk("R10 toggle low", {31'h0, pin_out}, 32'h0);
        sc_read(); sc_write(8'h14);

        // set and clear actions
        sc_write(8'h1C); hit_match();
        chk("R10 set", {31'h0, pin_out}, 32'h1);
        sc_write(8'h18); hit_match();
        chk("R10 clear", {31'h0, pin_out}, 32'h0);

        // disconnected output
        sc_write(8'h1C); hit_match();
        sc_write(8'h10);
        chk("R14 compare select off", {31'h0, pin_out}, 32'h0);
        sc_write(8'h0C);
        chk("R14 capture mode", {31'h0, pin_out}, 32'h0);

        // toggle on overflow and 0% duty
        sc_write(8'h18); hit_match();
        sc_write(8'h1A);
        cnt_val = 16'h0005; cnt_ovf = 1'b1; tick(); cnt_ovf = 1'b0;
        chk("R11 overflow toggle", {31'h0, pin_out}, 32'h1);
        hit_match();
        chk("R11 match clears", {31'h0, pin_out}, 32'h0);
        val_write(16'h0000);
        cnt_val = 16'h0000; cnt_ovf = 1'b1; tick(); cnt_ovf = 1'b0;
        cnt_val = 16'h0011;
        chk("R11 match beats overflow", {31'h0, pin_out}, 32'h0);
        sc_write(8'h18);
        cnt_val = 16'h0005; cnt_ovf = 1'b1; tick(); cnt_ovf = 1'b0;
        chk("R11 no toggle when disabled", {31'h0, pin_out}, 32'h0);

        // full duty
        sc_write(8'h19);
        chk("R12 forced high", {31'h0, pin_out}, 32'h1);
        sc_write(8'h18);
        chk("R12 release", {31'h0, pin_out}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule